// File: doc/BRIEF.md
# Triangle Sweep PWM Generator

This block produces a single PWM waveform whose duty cycle moves on its own. Once the host releases it, the duty starts at zero and climbs by a fixed step each time a PWM period ends, up to a programmable ceiling. It then falls by a separate step back toward zero and climbs again, over and over, so a low-pass filtered copy of the output traces a triangle. Separate dwell counts, measured in whole PWM periods, set how many period ends pass between two rising steps and between two falling steps.

The host programs the block through a plain write port (write enable, 3-bit register address, data word). Until the unlock value is written to the key register, the block is held idle with its output low and every parameter can be written freely. After unlock, writes still land in holding registers but only become active at the next period end, so a period in progress is never distorted. A one-cycle strobe marks the last cycle of every period. There is no data stream at the block's edge, so no valid/ready handshake is used; all pins are plain control and status.

Top module: `tri_sweep_pwm`

## Requirements
- R1: After reset and while locked, `pwm_o` and `period_end_o` stay low; a write to the key register (address 0) with any value other than 0xA leaves the block locked.
- R2: Writing 0xA to address 0 unlocks the block; parameters written while locked (address 1 period in ticks, 2 ceiling, 3 rising step, 4 falling step, 5 rising dwell, 6 falling dwell) are all in force from the first period after unlock.
- R3: The first period after unlock has zero duty and the sweep direction starts as rising.
- R4: Each period lasts exactly `period` clock cycles; within it `pwm_o` is high for min(compare, period) cycles, so a compare of 0 gives a constant low and a compare equal to the period gives a constant high.
- R5: The compare value changes only at a period end, and `period_end_o` is high for exactly the last cycle of each period.
- R6: While rising, at a period end with compare at or above the ceiling, the direction turns to falling and the compare is unchanged; otherwise a step adds the rising step (a step value of 0 counts as 1 tick), clamped at the ceiling.
- R7: While falling, at a period end with compare less than or equal to the falling step (0 counts as 1), the direction turns to rising and the compare is unchanged; otherwise a step subtracts the falling step.
- R8: Between two steps in one direction, that direction's dwell count of period ends is skipped; the rising and falling dwell counters are separate, each loaded at unlock and reloaded from its register after every step it allows. Direction turns are not delayed by dwell.
- R9: A parameter written while running takes effect at the end of the period in progress; that period keeps its old length and the step decision at that boundary uses the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 key, 1 period, 2 ceiling, 3 rise step, 4 fall step, 5 rise dwell, 6 fall dwell) |
| cfg_wdata | input | DATA_W (16) | Register write data |
| pwm_o | output | 1 | PWM output |
| period_end_o | output | 1 | High on the last cycle of each PWM period |

## Verification
The hardest state to reach from the ports is a parameter write that lands in the middle of a running period, because the new value must neither shorten that period nor alter the step taken at its end. The bench counts completed periods from the strobe, and right after a chosen period ends it writes a shorter period and a lower ceiling in the first cycles of the next one, then compares each captured period length and high time against a model that switches parameters one boundary later. Separate asymmetric dwell and step settings are run long enough to cross both direction turns several times, including a compare that equals the period.

// File: rtl/sweep_pwm_pkg.sv
package sweep_pwm_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_KEY      = 3'd0,
    REG_PERIOD   = 3'd1,
    REG_CEIL     = 3'd2,
    REG_UP_STEP  = 3'd3,
    REG_DN_STEP  = 3'd4,
    REG_UP_DWELL = 3'd5,
    REG_DN_DWELL = 3'd6
  } reg_addr_e;

  localparam int unsigned UNLOCK_VALUE = 32'hA;
endpackage

// File: rtl/sweep_cfg.sv
module sweep_cfg
  import sweep_pwm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic              run,
  output logic [CNT_W-1:0]  per,
  output logic [CNT_W-1:0]  ceil,
  output logic [CNT_W-1:0]  up_step,
  output logic [CNT_W-1:0]  dn_step,
  output logic [DLY_W-1:0]  up_dwell,
  output logic [DLY_W-1:0]  dn_dwell
);
  logic [CNT_W-1:0] sh_per, sh_ceil, sh_up, sh_dn;
  logic [DLY_W-1:0] sh_dwu, sh_dwd;
  logic [CNT_W-1:0] nx_per, nx_ceil, nx_up, nx_dn;
  logic [DLY_W-1:0] nx_dwu, nx_dwd;
  logic             key_hit;

  assign key_hit = we && (addr == REG_KEY) && (wdata == DATA_W'(UNLOCK_VALUE));

  always_comb begin
    nx_per  = sh_per;
    nx_ceil = sh_ceil;
    nx_up   = sh_up;
    nx_dn   = sh_dn;
    nx_dwu  = sh_dwu;
    nx_dwd  = sh_dwd;
    if (we) begin
      case (reg_addr_e'(addr))
        REG_PERIOD:   nx_per  = wdata[CNT_W-1:0];
        REG_CEIL:     nx_ceil = wdata[CNT_W-1:0];
        REG_UP_STEP:  nx_up   = wdata[CNT_W-1:0];
        REG_DN_STEP:  nx_dn   = wdata[CNT_W-1:0];
        REG_UP_DWELL: nx_dwu  = wdata[DLY_W-1:0];
        REG_DN_DWELL: nx_dwd  = wdata[DLY_W-1:0];
        default:      ;
      endcase
    end
  end

  // Holding copies follow every write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_per <= '0; sh_ceil <= '0; sh_up <= '0; sh_dn <= '0;
      sh_dwu <= '0; sh_dwd <= '0;
    end else begin
      sh_per <= nx_per; sh_ceil <= nx_ceil; sh_up <= nx_up; sh_dn <= nx_dn;
      sh_dwu <= nx_dwu; sh_dwd <= nx_dwd;
    end
  end

  // Working copies: free-running while locked, boundary-only while running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per <= '0; ceil <= '0; up_step <= '0; dn_step <= '0;
      up_dwell <= '0; dn_dwell <= '0;
    end else if (!run || tick) begin
      per <= nx_per; ceil <= nx_ceil; up_step <= nx_up; dn_step <= nx_dn;
      up_dwell <= nx_dwu; dn_dwell <= nx_dwd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run <= 1'b0;
    else if (key_hit) run <= 1'b1;
  end

  // R1: anything but the unlock write keeps the block locked
  a_r1_stay_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !key_hit) |=> !run);
  // R2: the unlock write releases the block on the next cycle
  a_r2_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> run);
  // R9: working period only moves at a boundary while running
  a_r9_boundary_load: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(per) && $stable(ceil));
endmodule

// File: rtl/sweep_period_ctr.sv
module sweep_period_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);
  logic [CNT_W:0] nxt;

  assign nxt  = {1'b0, cnt} + ONE;
  assign tick = run && (nxt >= {1'b0, per});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= nxt[CNT_W-1:0];
  end

  // R4: the counter never leaves the programmed period
  a_r4_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    (run && per != '0) |-> (cnt < per));
endmodule

// File: rtl/sweep_ctl.sv
module sweep_ctl #(
  parameter int CNT_W = 12,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] ceil,
  input  logic [CNT_W-1:0] up_step,
  input  logic [CNT_W-1:0] dn_step,
  input  logic [DLY_W-1:0] up_dwell,
  input  logic [DLY_W-1:0] dn_dwell,
  output logic [CNT_W-1:0] cmp,
  output logic             dir_dn
);
  localparam logic [CNT_W-1:0] ONE_TICK = CNT_W'(1);

  logic [CNT_W-1:0] up_eff, dn_eff, inc_val;
  logic [CNT_W:0]   sum;
  logic [DLY_W-1:0] wait_up, wait_dn;

  assign up_eff  = (up_step == '0) ? ONE_TICK : up_step;
  assign dn_eff  = (dn_step == '0) ? ONE_TICK : dn_step;
  assign sum     = {1'b0, cmp} + {1'b0, up_eff};
  assign inc_val = (sum > {1'b0, ceil}) ? ceil : sum[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp <= '0; dir_dn <= 1'b0; wait_up <= '0; wait_dn <= '0;
    end else if (!run) begin
      cmp <= '0; dir_dn <= 1'b0; wait_up <= up_dwell; wait_dn <= dn_dwell;
    end else if (tick) begin
      if (!dir_dn) begin
        if (cmp >= ceil)        dir_dn <= 1'b1;
        else if (wait_up == '0) begin
          cmp <= inc_val; wait_up <= up_dwell;
        end else                wait_up <= wait_up - 1'b1;
      end else begin
        if (cmp <= dn_eff)      dir_dn <= 1'b0;
        else if (wait_dn == '0) begin
          cmp <= cmp - dn_eff; wait_dn <= dn_dwell;
        end else                wait_dn <= wait_dn - 1'b1;
      end
    end
  end

  // R3: release always begins rising from zero
  a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cmp == '0) && !dir_dn);
  // R5: compare holds between period ends
  a_r5_cmp_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cmp));
  // R6: at the ceiling the direction turns without a step
  a_r6_turn_top: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !dir_dn && cmp >= ceil) |=> dir_dn && $stable(cmp));
  // R7: near zero the direction turns without a step
  a_r7_turn_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && dir_dn && cmp <= dn_eff) |=> !dir_dn && $stable(cmp));
  // R8: a pending rising dwell holds the compare and counts down
  a_r8_dwell_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !dir_dn && cmp < ceil && wait_up != '0)
      |=> $stable(cmp) && (wait_up == DLY_W'($past(wait_up) - 1'b1)));
endmodule

// File: rtl/tri_sweep_pwm.sv
module tri_sweep_pwm
  import sweep_pwm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              pwm_o,
  output logic              period_end_o
);
  logic             run, tick, dir_dn;
  logic [CNT_W-1:0] per, ceil, up_step, dn_step, cnt, cmp;
  logic [DLY_W-1:0] up_dwell, dn_dwell;

  sweep_cfg #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DLY_W(DLY_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .tick(tick), .run(run), .per(per), .ceil(ceil), .up_step(up_step),
    .dn_step(dn_step), .up_dwell(up_dwell), .dn_dwell(dn_dwell)
  );

  sweep_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run), .per(per), .cnt(cnt), .tick(tick)
  );

  sweep_ctl #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .ceil(ceil),
    .up_step(up_step), .dn_step(dn_step), .up_dwell(up_dwell),
    .dn_dwell(dn_dwell), .cmp(cmp), .dir_dn(dir_dn)
  );

  assign pwm_o        = run && (cnt < cmp);
  assign period_end_o = tick;

  // R4: a compare at or above the period drives a full-high period
  a_r4_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run && per != '0 && cmp >= per) |-> pwm_o);
  // R1: nothing toggles while locked
  a_r1_quiet_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !period_end_o && !pwm_o);
endmodule

// File: tb/tri_sweep_pwm_tb_top.sv
module tri_sweep_pwm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        pwm_o, period_end_o;

  int checks = 0;
  int fails  = 0;
  int nper = 0, cl = 0, ch = 0;
  int plen [0:255];
  int phi  [0:255];
  int m_per, m_ceil, m_up, m_dn, m_dwu, m_dwd;
  int m_cmp, m_dir, m_wu, m_wd;

  always #4 clk = ~clk;

  tri_sweep_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
    .pwm_o(pwm_o), .period_end_o(period_end_o)
  );

  // Period capture from the ports, sampled at the falling edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      nper = 0; cl = 0; ch = 0;
    end else if (we && addr == 3'd0 && wdata == 16'hA) begin
      cl = 0; ch = 0;
    end else begin
      cl++;
      if (pwm_o) ch++;
      if (period_end_o) begin
        if (nper < 256) begin plen[nper] = cl; phi[nper] = ch; end
        nper++; cl = 0; ch = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    we = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic do_reset();
    we = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(input int p, input int c, input int u, input int d,
                       input int wu, input int wd);
    m_per = p; m_ceil = c; m_up = u; m_dn = d; m_dwu = wu; m_dwd = wd;
    wr(1, p); wr(2, c); wr(3, u); wr(4, d); wr(5, wu); wr(6, wd);
  endtask

  task automatic model_start();
    m_cmp = 0; m_dir = 0; m_wu = m_dwu; m_wd = m_dwd;
  endtask

  task automatic model_step();
    int ue, de, s;
    ue = (m_up == 0) ? 1 : m_up;
    de = (m_dn == 0) ? 1 : m_dn;
    if (m_dir == 0) begin
      if (m_cmp >= m_ceil) m_dir = 1;
      else if (m_wu == 0) begin
        s = m_cmp + ue;
        m_cmp = (s > m_ceil) ? m_ceil : s;
        m_wu = m_dwu;
      end else m_wu--;
    end else begin
      if (m_cmp <= de) m_dir = 0;
      else if (m_wd == 0) begin m_cmp -= de; m_wd = m_dwd; end
      else m_wd--;
    end
  endtask

  // Compare captured periods first..last with the model, then advance it.
  task automatic check_span(input int first, input int last);
    int eh;
    wait (nper > last);
    for (int i = first; i <= last; i++) begin
      eh = (m_cmp < m_per) ? m_cmp : m_per;
      chk(plen[i] == m_per, "R4 R5 period length", plen[i], m_per);
      chk(phi[i] == eh, "R6 R7 R8 high time", phi[i], eh);
      model_step();
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    chk(pwm_o == 1'b0, "R1 reset pwm", int'(pwm_o), 0);
    chk(period_end_o == 1'b0, "R1 reset strobe", int'(period_end_o), 0);
  endtask

  task automatic t_locked();
    int hi_seen, st_seen;
    do_reset();
    setup(4, 4, 0, 2, 0, 0);
    wr(0, 5);
    hi_seen = 0; st_seen = 0;
    repeat (30) begin
      @(negedge clk);
      if (pwm_o) hi_seen++;
      if (period_end_o) st_seen++;
    end
    chk(hi_seen == 0, "R1 locked pwm low", hi_seen, 0);
    chk(st_seen == 0, "R1 locked no strobe", st_seen, 0);
  endtask

  task automatic t_sweep_basic();
    do_reset();
    setup(4, 4, 0, 2, 0, 0);
    wr(0, 'hA);
    model_start();
    wait (nper > 4);
    chk(phi[0] == 0, "R3 first period zero duty", phi[0], 0);
    chk(phi[4] == 4, "R4 compare equal to period is full high", phi[4], 4);
    chk(plen[0] == 4, "R2 period from locked write", plen[0], 4);
    check_span(0, 19);
  endtask

  task automatic t_dwell();
    do_reset();
    setup(5, 4, 2, 0, 2, 1);
    wr(0, 'hA);
    model_start();
    wait (nper > 3);
    chk(phi[3] == 2, "R8 rising dwell of two periods", phi[3], 2);
    check_span(0, 29);
  endtask

  task automatic t_midrun();
    do_reset();
    setup(6, 6, 1, 1, 0, 0);
    wr(0, 'hA);
    model_start();
    wait (nper >= 3);
    wr(1, 3);
    wr(2, 2);
    check_span(0, 3);
    m_per = 3; m_ceil = 2;
    chk(plen[3] == 6, "R9 running period keeps old length", plen[3], 6);
    check_span(4, 14);
    chk(plen[4] == 3, "R9 new length after boundary", plen[4], 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nper, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_locked();
    t_sweep_basic();
    t_dwell();
    t_midrun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule